// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned operands and reports, on three registered one-hot outputs, whether the first is less than, greater than or equal to the second. It is built from fixed-width comparator slices of 4 bits each.

Each slice takes a three-signal status from its less-significant side. It passes on a new status. If every bit pair in the slice matches, the slice forwards the incoming status unchanged. If any bit pair differs, the most significant differing pair sets the result.

A parameter picks one of two arrangements of slices:
- Linear chain: the status ripples through every slice, so the depth is one slice per 4-bit group.
- Tree: every group is compared at once. The less and greater results of each group are then fed to the next level as that group's operand bit pair, so the depth grows with the base-4 logarithm of the group count. The tree pads a level whose width is not a multiple of the slice width with equal zero bits.

The result is captured in a register on every clock edge, one cycle after the operands are presented.

Top module: `mag_cmp_top`

## Requirements
- R1: In every cycle exactly one of `a_lt_b`, `a_gt_b`, `a_eq_b` is 1.
- R2: One cycle after operands are presented, `a_eq_b` is 1 exactly when `opnd_a` equals `opnd_b`.
- R3: One cycle after operands are presented, `a_lt_b` is 1 exactly when `opnd_a` is numerically smaller than `opnd_b`, both treated as unsigned.
- R4: One cycle after operands are presented, `a_gt_b` is 1 exactly when `opnd_a` is numerically larger than `opnd_b`, both treated as unsigned.
- R5: The most significant bit position at which the operands differ decides the result, whatever the bits below it hold. A 0 in `opnd_a` there gives less; a 1 gives greater.
- R6: With `TREE_MODE` = 0, the slices form a linear chain. The lowest slice is seeded with equal=1, less=0, greater=0. A slice whose operand groups match forwards its neighbour's status unchanged, so a difference confined to the lowest group still reaches the outputs.
- R7: With `TREE_MODE` = 1, the tree gives the same result as the chain for every operand pair. This includes slice counts that are not a power of four, where a level is padded with equal bits.
- R8: While `rst` is 1 at a clock edge, the outputs become `a_eq_b`=1, `a_lt_b`=0, `a_gt_b`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | NUM_SLICES*SLICE_W | First unsigned operand |
| opnd_b | input | NUM_SLICES*SLICE_W | Second unsigned operand |
| a_lt_b | output | 1 | Registered: first operand below second |
| a_gt_b | output | 1 | Registered: first operand above second |
| a_eq_b | output | 1 | Registered: operands equal |

## Verification
The bench builds three copies of the block and drives them from the same operands:
- a 16-bit linear chain of four slices;
- a 16-bit tree, whose four groups meet in a single second-level slice;
- a 20-bit tree of five slices, whose second level needs two padded slices and a third level.

The 20-bit tree reaches the recursion and padding paths, which a power-of-four count never enters. Walking single-bit differences and pairs that match above a chosen group check that both the cascade forwarding and the tree combining let a low-order difference through.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cmp_stat_t;

  localparam cmp_stat_t CMP_SEED = '{lt: 1'b0, gt: 1'b0, eq: 1'b1};

endpackage

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] grp_a,
  input  logic [SLICE_W-1:0] grp_b,
  input  cmp_stat_t          stat_in,
  output cmp_stat_t          stat_out
);

  // Scan upward so that the highest differing pair is the last to write.
  always_comb begin
    stat_out = stat_in;
    for (int i = 0; i < SLICE_W; i++) begin
      if (grp_a[i] != grp_b[i]) begin
        stat_out.lt = ~grp_a[i];
        stat_out.gt = grp_a[i];
        stat_out.eq = 1'b0;
      end
    end
  end

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int SLICE_W    = 4
) (
  input  logic [NUM_SLICES*SLICE_W-1:0] opnd_a,
  input  logic [NUM_SLICES*SLICE_W-1:0] opnd_b,
  output cmp_stat_t                     result
);

  cmp_stat_t link [NUM_SLICES+1];

  // R6: the lowest slice sees "equal so far"
  assign link[0] = CMP_SEED;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_stage
    mag_cmp_slice #(.SLICE_W(SLICE_W)) u_slice (
      .grp_a   (opnd_a[k*SLICE_W +: SLICE_W]),
      .grp_b   (opnd_b[k*SLICE_W +: SLICE_W]),
      .stat_in (link[k]),
      .stat_out(link[k+1])
    );
  end

  assign result = link[NUM_SLICES];

endmodule

// File: rtl/mag_cmp_tree.sv
module mag_cmp_tree
  import mag_cmp_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int SLICE_W = 4
) (
  input  logic [IN_W-1:0] bits_a,
  input  logic [IN_W-1:0] bits_b,
  output cmp_stat_t       result
);

  localparam int GROUPS = (IN_W + SLICE_W - 1) / SLICE_W;
  localparam int PAD_W  = GROUPS * SLICE_W;

  // Zero padding on both sides compares as equal and never decides.
  logic [PAD_W-1:0]  pad_a;
  logic [PAD_W-1:0]  pad_b;
  logic [GROUPS-1:0] grp_gt;
  logic [GROUPS-1:0] grp_lt;
  cmp_stat_t         grp_stat [GROUPS];

  assign pad_a = PAD_W'(bits_a);
  assign pad_b = PAD_W'(bits_b);

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    mag_cmp_slice #(.SLICE_W(SLICE_W)) u_slice (
      .grp_a   (pad_a[g*SLICE_W +: SLICE_W]),
      .grp_b   (pad_b[g*SLICE_W +: SLICE_W]),
      .stat_in (CMP_SEED),
      .stat_out(grp_stat[g])
    );
    assign grp_gt[g] = grp_stat[g].gt;
    assign grp_lt[g] = grp_stat[g].lt;
  end

  if (GROUPS == 1) begin : g_root
    assign result = grp_stat[0];
  end else begin : g_next
    // A group's greater flag stands in for its A bit, less for its B bit.
    mag_cmp_tree #(.IN_W(GROUPS), .SLICE_W(SLICE_W)) u_level (
      .bits_a(grp_gt),
      .bits_b(grp_lt),
      .result(result)
    );
  end

endmodule

// File: rtl/mag_cmp_top.sv
module mag_cmp_top
  import mag_cmp_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int SLICE_W    = 4,
  parameter bit TREE_MODE  = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SLICES*SLICE_W-1:0] opnd_a,
  input  logic [NUM_SLICES*SLICE_W-1:0] opnd_b,
  output logic                          a_lt_b,
  output logic                          a_gt_b,
  output logic                          a_eq_b
);

  localparam int OP_W = NUM_SLICES * SLICE_W;

  cmp_stat_t comb_res;
  cmp_stat_t res_q;

  if (TREE_MODE) begin : g_tree
    mag_cmp_tree #(.IN_W(OP_W), .SLICE_W(SLICE_W)) u_tree (
      .bits_a(opnd_a),
      .bits_b(opnd_b),
      .result(comb_res)
    );
  end else begin : g_chain
    mag_cmp_chain #(.NUM_SLICES(NUM_SLICES), .SLICE_W(SLICE_W)) u_chain (
      .opnd_a(opnd_a),
      .opnd_b(opnd_b),
      .result(comb_res)
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= CMP_SEED;
    end else begin
      res_q <= comb_res;
    end
  end

  assign a_lt_b = res_q.lt;
  assign a_gt_b = res_q.gt;
  assign a_eq_b = res_q.eq;

  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones({a_lt_b, a_gt_b, a_eq_b}) == 1);

  a_r2_equal: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_eq_b == ($past(opnd_a) == $past(opnd_b))));

  a_r3_less: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_lt_b == ($past(opnd_a) < $past(opnd_b))));

  a_r4_greater: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_gt_b == ($past(opnd_a) > $past(opnd_b))));

  a_r8_reset: assert property (@(posedge clk)
    $past(rst) |-> (a_eq_b && !a_lt_b && !a_gt_b));

endmodule

// File: tb/test_mag_cmp_top.sv
module test_mag_cmp_top;

  localparam int W16 = 16;
  localparam int W20 = 20;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [W20-1:0] op_a = '0;
  logic [W20-1:0] op_b = '0;

  logic lt_c, gt_c, eq_c;
  logic lt_t, gt_t, eq_t;
  logic lt_w, gt_w, eq_w;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mag_cmp_top #(.NUM_SLICES(4), .SLICE_W(4), .TREE_MODE(1'b0)) i_mag_cmp_top (
    .clk(clk), .rst(rst), .opnd_a(op_a[W16-1:0]), .opnd_b(op_b[W16-1:0]),
    .a_lt_b(lt_c), .a_gt_b(gt_c), .a_eq_b(eq_c));

  mag_cmp_top #(.NUM_SLICES(4), .SLICE_W(4), .TREE_MODE(1'b1)) i_mag_cmp_top_tree (
    .clk(clk), .rst(rst), .opnd_a(op_a[W16-1:0]), .opnd_b(op_b[W16-1:0]),
    .a_lt_b(lt_t), .a_gt_b(gt_t), .a_eq_b(eq_t));

  mag_cmp_top #(.NUM_SLICES(5), .SLICE_W(4), .TREE_MODE(1'b1)) i_mag_cmp_top_wide (
    .clk(clk), .rst(rst), .opnd_a(op_a), .opnd_b(op_b),
    .a_lt_b(lt_w), .a_gt_b(gt_w), .a_eq_b(eq_w));

  task automatic check3(input string req, input string who,
                        input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s a=%h b=%h actual(lt,gt,eq)=%b expected=%b",
               req, who, op_a, op_b, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the capturing rising edge.
  task automatic apply(input logic [W20-1:0] a, input logic [W20-1:0] b,
                       input string req);
    logic [W16-1:0] a16;
    logic [W16-1:0] b16;
    @(negedge clk);
    op_a = a;
    op_b = b;
    @(posedge clk);
    #1;
    a16 = a[W16-1:0];
    b16 = b[W16-1:0];
    check3(req, "chain16", {lt_c, gt_c, eq_c}, {a16 < b16, a16 > b16, a16 == b16});
    check3(req, "tree16",  {lt_t, gt_t, eq_t}, {a16 < b16, a16 > b16, a16 == b16});
    check3(req, "tree20",  {lt_w, gt_w, eq_w}, {a < b, a > b, a == b});
    check3("R1", "onehot", {$countones({lt_c, gt_c, eq_c}) == 1,
                            $countones({lt_t, gt_t, eq_t}) == 1,
                            $countones({lt_w, gt_w, eq_w}) == 1}, 3'b111);
  endtask

  task automatic test_reset();
    @(negedge clk);
    op_a = 20'hFFFFF;
    op_b = 20'h00001;
    rst  = 1'b1;
    @(posedge clk);
    #1;
    check3("R8", "chain16", {lt_c, gt_c, eq_c}, 3'b001);
    check3("R8", "tree16",  {lt_t, gt_t, eq_t}, 3'b001);
    check3("R8", "tree20",  {lt_w, gt_w, eq_w}, 3'b001);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_equal();
    apply(20'h00000, 20'h00000, "R2");
    apply(20'hFFFFF, 20'hFFFFF, "R2");
    apply(20'h5A3C9, 20'h5A3C9, "R2");
  endtask

  task automatic test_msb_decides();
    apply(20'h7FFFF, 20'h80000, "R5");
    apply(20'h80000, 20'h7FFFF, "R5");
    apply(20'h07FFF, 20'h08000, "R5");
    apply(20'h08000, 20'h07FFF, "R5");
    apply(20'h00010, 20'h0000F, "R3");
  endtask

  task automatic test_low_group();
    apply(20'hABCD0, 20'hABCD1, "R6");
    apply(20'hABCD9, 20'hABCD8, "R6");
    apply(20'h1234E, 20'h1234F, "R7");
  endtask

  task automatic test_walking();
    for (int i = 0; i < W20; i++) begin
      apply(20'h00000 | (20'h1 << i), 20'h00000, "R4");
      apply(20'hFFFFF & ~(20'h1 << i), 20'hFFFFF, "R3");
    end
  endtask

  task automatic test_random();
    logic [W20-1:0] lfsr = 20'hACE1B;
    logic [W20-1:0] ra;
    logic [W20-1:0] rb;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
      ra = lfsr;
      lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
      rb = lfsr;
      if (n % 3 == 1) rb = (ra & 20'hFFF00) | (rb & 20'h000FF);
      if (n % 3 == 2) rb = (ra & 20'hFFFF0) | (rb & 20'h0000F);
      apply(ra, rb, "R7");
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    test_equal();
    test_msb_decides();
    test_low_group();
    test_walking();
    test_random();
    test_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule